// File: doc/BRIEF.md
# Privilege-Filtered Event Counter Bank

This block is a compact performance-monitoring unit. It holds three fixed-function event counters and four general counters, all 48 bits wide. Each fixed counter is steered by a four-bit control nibble. The nibble chooses:

- whether the counter runs at privilege level 0 (supervisor), above 0 (user), or both;
- whether it counts only the owning thread's events or the events of every thread on the core;
- whether its overflow drives the interrupt.

The general counters take an already-selected event pulse and count every pulse.

When a counter wraps, it sets a sticky flag in a read-only status word. General counter g uses bit g, and fixed counter n uses bit 32+n. Software clears flags by writing ones to a separate clear register. The interrupt output is a level, held high while any enabled flag is set. Software reaches the control nibbles, the status word, the clear register and every counter value through one plain single-cycle register port. Writes take effect on the clock edge and reads are combinational.

The block has no streaming data path, so it uses no valid/ready handshake. Event pulses, privilege level and the register port are plain synchronous pins sampled on every rising edge, and the block never applies back-pressure.

Top module: `pmu_counter_bank`

## Requirements
- R1: After reset all counters, the control register and the status word are zero and `irq_o` is low.
- R2: A fixed counter n increments only while its supervisor bit (control bit 4n) is set and `priv_i` is 0, or while its user bit (bit 4n+1) is set and `priv_i` is not 0. With both bits clear it holds its value.
- R3: With the any-thread bit (bit 4n+2) clear, a fixed counter adds 1 for a pulse on thread 0 (`fix_evt_i[2n]`) and ignores thread 1 (`fix_evt_i[2n+1]`). With the bit set, it adds the number of asserted pulses (0, 1 or 2).
- R4: General counter g adds 1 for each cycle in which `gen_evt_i[g]` is high, whatever the privilege level.
- R5: A carry out of a counter's 48 bits wraps it modulo 2^48. On the same clock edge, the carry sets status bit g for general counter g, or status bit 32+n for fixed counter n.
- R6: Status bits 31:4 and 63:35 always read zero, and a write to the status address (1) changes nothing.
- R7: A write to address 2 clears every status flag whose data bit is 1. A flag being set in the same cycle stays set, and a flag stays set otherwise.
- R8: `irq_o` is high exactly when any general flag is set, or a fixed flag n is set while control bit 4n+3 is 1.
- R9: A write to a counter address (4+g general, 8+n fixed) loads the counter from data bits 47:0. An event in that same cycle is dropped and raises no overflow.
- R10: Address 0 holds the control register. A write stores data bits 11:0, and a read returns them with bits 63:12 zero.
- R11: Reads are combinational. Address 0 returns control, 1 returns status, 4..7 and 8..10 return the counters zero-extended, and address 2 and all unused addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_i | input | 2 | Current privilege level, 0 is supervisor |
| fix_evt_i | input | 6 | Fixed-counter event pulses, bit 2n+t is counter n, thread t |
| gen_evt_i | input | 4 | Pre-selected event pulse for each general counter |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data for `reg_addr_i` |
| fix_ctr_o | output | 144 | Fixed counter values, counter n in bits 48n+47:48n |
| gen_ctr_o | output | 192 | General counter values, counter g in bits 48g+47:48g |
| status_o | output | 64 | Overflow status word |
| irq_o | output | 1 | Level performance-monitoring interrupt |

## Verification
Directed patterns give each fixed counter a different privilege setting and then sweep the privilege level. This separates the supervisor gate from the user gate. A pulse on the sibling thread alone, then on both threads, separates own-thread counting from any-thread counting and checks the add-by-two step. Counters preloaded to all ones are driven with a load-plus-event collision and with a clear-plus-overflow collision. These show that the load wins over the event and that a new flag wins over its clear. A long random phase mixes privilege changes, random control nibbles, near-wrap preloads and stray status writes, and compares every counter, flag, the interrupt and a random register read against a bench model each cycle.

// File: rtl/pmu_bank_pkg.sv
package pmu_bank_pkg;

  // register address map (offsets in the register port)
  localparam int ADR_CTL    = 0;
  localparam int ADR_STATUS = 1;
  localparam int ADR_CLEAR  = 2;
  localparam int GEN_BASE   = 4;

  // status word: fixed counter flags start here
  localparam int FIX_STAT_BASE = 32;

  // thread whose events count when any-thread is off
  localparam int OWN_THREAD = 0;

  // control nibble layout, lsb first: supervisor, user, any-thread, irq
  typedef struct packed {
    logic irq_en;
    logic any_thr;
    logic usr_en;
    logic sup_en;
  } fix_ctl_t;

endpackage

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter #(
  parameter int W     = 48,
  parameter int INC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [W-1:0]     load_val_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [W-1:0]     value_o,
  output logic             wrap_o
);
  logic [W:0]   sum;
  logic [W-1:0] cnt_q;

  always_comb begin
    sum = {1'b0, cnt_q} + {{(W + 1 - INC_W){1'b0}}, inc_i};
  end

  // a carry only matters when no load overrides it
  assign wrap_o  = sum[W] & ~load_i;
  assign value_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else             cnt_q <= sum[W-1:0];
  end
endmodule

// File: rtl/pmu_fixed_gate.sv
module pmu_fixed_gate #(
  parameter int THREADS = 2,
  parameter int INC_W   = 2
) (
  input  logic               sup_en_i,
  input  logic               usr_en_i,
  input  logic               any_thr_i,
  input  logic [1:0]         priv_i,
  input  logic [THREADS-1:0] evt_i,
  output logic [INC_W-1:0]   inc_o
);
  import pmu_bank_pkg::*;

  logic             allowed;
  logic [INC_W-1:0] cnt;

  always_comb begin
    allowed = (sup_en_i && priv_i == 2'd0) || (usr_en_i && priv_i != 2'd0);
    cnt     = '0;
    for (int t = 0; t < THREADS; t++) begin
      if (evt_i[t] && (any_thr_i || t == OWN_THREAD)) cnt = cnt + INC_W'(1);
    end
    inc_o = allowed ? cnt : '0;
  end
endmodule

// File: rtl/pmu_ovf_status.sv
module pmu_ovf_status #(
  parameter int NUM_GEN   = 4,
  parameter int NUM_FIXED = 3,
  parameter int DATA_W    = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_GEN-1:0]   set_gen_i,
  input  logic [NUM_FIXED-1:0] set_fix_i,
  input  logic                 clr_en_i,
  input  logic [DATA_W-1:0]    clr_mask_i,
  input  logic [NUM_FIXED-1:0] fix_irq_en_i,
  output logic [DATA_W-1:0]    status_o,
  output logic                 irq_o
);
  import pmu_bank_pkg::*;

  logic [NUM_GEN-1:0]   gen_q, gen_clr;
  logic [NUM_FIXED-1:0] fix_q, fix_clr;

  assign gen_clr = clr_en_i ? clr_mask_i[NUM_GEN-1:0] : '0;
  assign fix_clr = clr_en_i ? clr_mask_i[FIX_STAT_BASE +: NUM_FIXED] : '0;

  // a new overflow wins over a clear of the same flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= '0;
      fix_q <= '0;
    end else begin
      gen_q <= (gen_q & ~gen_clr) | set_gen_i;
      fix_q <= (fix_q & ~fix_clr) | set_fix_i;
    end
  end

  always_comb begin
    status_o = '0;
    status_o[NUM_GEN-1:0] = gen_q;
    status_o[FIX_STAT_BASE +: NUM_FIXED] = fix_q;
  end

  assign irq_o = (|gen_q) | (|(fix_q & fix_irq_en_i));
endmodule

// File: rtl/pmu_counter_bank.sv
module pmu_counter_bank #(
  parameter int NUM_GEN   = 4,
  parameter int NUM_FIXED = 3,
  parameter int CTR_W     = 48,
  parameter int THREADS   = 2,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   priv_i,
  input  logic [NUM_FIXED*THREADS-1:0] fix_evt_i,
  input  logic [NUM_GEN-1:0]           gen_evt_i,
  input  logic                         reg_wr_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [DATA_W-1:0]            reg_wdata_i,
  output logic [DATA_W-1:0]            reg_rdata_o,
  output logic [NUM_FIXED*CTR_W-1:0]   fix_ctr_o,
  output logic [NUM_GEN*CTR_W-1:0]     gen_ctr_o,
  output logic [DATA_W-1:0]            status_o,
  output logic                         irq_o
);
  import pmu_bank_pkg::*;

  localparam int INC_W    = $clog2(THREADS + 1);
  localparam int CTL_W    = 4 * NUM_FIXED;
  localparam int FIX_BASE = GEN_BASE + NUM_GEN;

  logic [CTL_W-1:0]     ctl_q;
  logic                 wr_ctl, wr_clr;
  logic [NUM_GEN-1:0]   gen_wrap;
  logic [NUM_FIXED-1:0] fix_wrap, fix_irq_en;
  logic [CTR_W-1:0]     gen_val [NUM_GEN];
  logic [CTR_W-1:0]     fix_val [NUM_FIXED];

  assign wr_ctl = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_CTL));
  assign wr_clr = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_CLEAR));

  // control register: only the nibble bits are stored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (wr_ctl) ctl_q <= reg_wdata_i[CTL_W-1:0];
  end

  // general counters: one pre-selected pulse each
  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    logic ld;
    assign ld = reg_wr_i && (reg_addr_i == ADDR_W'(GEN_BASE + g));
    pmu_evt_counter #(.W(CTR_W), .INC_W(INC_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ld),
      .load_val_i (reg_wdata_i[CTR_W-1:0]),
      .inc_i      (INC_W'(gen_evt_i[g])),
      .value_o    (gen_val[g]),
      .wrap_o     (gen_wrap[g])
    );
    assign gen_ctr_o[g*CTR_W +: CTR_W] = gen_val[g];
  end

  // fixed counters: privilege and thread gating per nibble
  for (genvar f = 0; f < NUM_FIXED; f++) begin : g_fix
    fix_ctl_t         nib;
    logic             ld;
    logic [INC_W-1:0] inc;

    assign nib = fix_ctl_t'(ctl_q[4*f +: 4]);
    assign ld  = reg_wr_i && (reg_addr_i == ADDR_W'(FIX_BASE + f));
    assign fix_irq_en[f] = nib.irq_en;

    pmu_fixed_gate #(.THREADS(THREADS), .INC_W(INC_W)) u_gate (
      .sup_en_i  (nib.sup_en),
      .usr_en_i  (nib.usr_en),
      .any_thr_i (nib.any_thr),
      .priv_i    (priv_i),
      .evt_i     (fix_evt_i[f*THREADS +: THREADS]),
      .inc_o     (inc)
    );

    pmu_evt_counter #(.W(CTR_W), .INC_W(INC_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ld),
      .load_val_i (reg_wdata_i[CTR_W-1:0]),
      .inc_i      (inc),
      .value_o    (fix_val[f]),
      .wrap_o     (fix_wrap[f])
    );
    assign fix_ctr_o[f*CTR_W +: CTR_W] = fix_val[f];
  end

  pmu_ovf_status #(.NUM_GEN(NUM_GEN), .NUM_FIXED(NUM_FIXED), .DATA_W(DATA_W)) u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_gen_i    (gen_wrap),
    .set_fix_i    (fix_wrap),
    .clr_en_i     (wr_clr),
    .clr_mask_i   (reg_wdata_i),
    .fix_irq_en_i (fix_irq_en),
    .status_o     (status_o),
    .irq_o        (irq_o)
  );

  // combinational read mux
  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(ADR_CTL))    reg_rdata_o[CTL_W-1:0] = ctl_q;
    if (reg_addr_i == ADDR_W'(ADR_STATUS)) reg_rdata_o = status_o;
    for (int g = 0; g < NUM_GEN; g++) begin
      if (reg_addr_i == ADDR_W'(GEN_BASE + g)) reg_rdata_o = DATA_W'(gen_val[g]);
    end
    for (int f = 0; f < NUM_FIXED; f++) begin
      if (reg_addr_i == ADDR_W'(FIX_BASE + f)) reg_rdata_o = DATA_W'(fix_val[f]);
    end
  end
endmodule

// File: rtl/pmu_counter_bank_chk.sv
module pmu_counter_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_i,
  input logic [3:0]  reg_addr_i,
  input logic [47:0] ld_val,
  input logic        clr_bit32,
  input logic [47:0] fix0_val,
  input logic [1:0]  fix0_modes,
  input logic [63:0] status_o,
  input logic        irq_o
);
  // R6: reserved status bits never rise
  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[31:4] == '0) && (status_o[63:35] == '0));

  // R8: no flag, no interrupt
  p_quiet_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == '0) |-> !irq_o);

  // R9: a load of fixed counter 0 lands on the next edge
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 4'd8) |=> (fix0_val == $past(ld_val)));

  // R7: a flag holds unless its own clear bit is written
  p_sticky_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[32] && !(reg_wr_i && reg_addr_i == 4'd2 && clr_bit32)) |=> status_o[32]);

  // R2: both privilege enables off freezes the counter
  p_gated_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fix0_modes == 2'b00 && !(reg_wr_i && reg_addr_i == 4'd8)) |=> $stable(fix0_val));
endmodule

bind pmu_counter_bank pmu_counter_bank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .ld_val     (reg_wdata_i[47:0]),
  .clr_bit32  (reg_wdata_i[32]),
  .fix0_val   (fix_ctr_o[47:0]),
  .fix0_modes (ctl_q[1:0]),
  .status_o   (status_o),
  .irq_o      (irq_o)
);

// File: tb/pmu_counter_bank_tb.sv
module pmu_counter_bank_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]   priv = '0;
  logic [5:0]   fix_evt = '0;
  logic [3:0]   gen_evt = '0;
  logic         wr = 1'b0;
  logic [3:0]   addr = '0;
  logic [63:0]  wdata = '0;
  logic [63:0]  rdata, status;
  logic [143:0] fix_ctr;
  logic [191:0] gen_ctr;
  logic         irq;

  pmu_counter_bank u_dut (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .fix_evt_i(fix_evt), .gen_evt_i(gen_evt),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .fix_ctr_o(fix_ctr), .gen_ctr_o(gen_ctr), .status_o(status), .irq_o(irq)
  );

  logic [47:0] m_fix [3];
  logic [47:0] m_gen [4];
  logic [11:0] m_ctl;
  logic [63:0] m_st;
  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] fix_inc(int f);
    logic [3:0] nib = m_ctl[4*f +: 4];
    logic en = (nib[0] && priv == 2'd0) || (nib[1] && priv != 2'd0);
    if (!en) return 2'd0;
    if (nib[2]) return {1'b0, fix_evt[2*f]} + {1'b0, fix_evt[2*f+1]};
    return {1'b0, fix_evt[2*f]};
  endfunction

  function automatic logic m_irq();
    logic r = |m_st[3:0];
    for (int f = 0; f < 3; f++) r |= m_st[32+f] & m_ctl[4*f+3];
    return r;
  endfunction

  function automatic logic [63:0] m_read(logic [3:0] a);
    if (a == 4'd0) return {52'd0, m_ctl};
    if (a == 4'd1) return m_st;
    if (a >= 4'd4 && a <= 4'd7) return {16'd0, m_gen[a-4]};
    if (a >= 4'd8 && a <= 4'd10) return {16'd0, m_fix[a-8]};
    return 64'd0;
  endfunction

  task automatic model_step();
    logic [63:0] st = m_st;
    logic [48:0] s;
    if (wr && addr == 4'd2) st &= ~wdata;
    for (int f = 0; f < 3; f++) begin
      if (wr && addr == 4'(8+f)) m_fix[f] = wdata[47:0];
      else begin
        s = {1'b0, m_fix[f]} + {47'd0, fix_inc(f)};
        if (s[48]) st[32+f] = 1'b1;
        m_fix[f] = s[47:0];
      end
    end
    for (int g = 0; g < 4; g++) begin
      if (wr && addr == 4'(4+g)) m_gen[g] = wdata[47:0];
      else begin
        s = {1'b0, m_gen[g]} + {48'd0, gen_evt[g]};
        if (s[48]) st[g] = 1'b1;
        m_gen[g] = s[47:0];
      end
    end
    if (wr && addr == 4'd0) m_ctl = wdata[11:0];
    m_st = st & 64'h0000_0007_0000_000F;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; fix_evt = '0; gen_evt = '0;
  endtask

  task automatic wreg(logic [3:0] a, logic [63:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick();
  endtask

  task automatic cmp_all();
    for (int f = 0; f < 3; f++) chk("R2 fixed counter", {16'd0, fix_ctr[f*48 +: 48]}, {16'd0, m_fix[f]});
    for (int g = 0; g < 4; g++) chk("R4 general counter", {16'd0, gen_ctr[g*48 +: 48]}, {16'd0, m_gen[g]});
    chk("R5 status", status, m_st);
    chk("R8 irq", {63'd0, irq}, {63'd0, m_irq()});
  endtask

  task automatic rd_chk(string tag, logic [3:0] a);
    addr = a;
    #0.5;
    chk(tag, rdata, m_read(a));
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog expired act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 3; i++) m_fix[i] = '0;
    for (int i = 0; i < 4; i++) m_gen[i] = '0;
    m_ctl = '0; m_st = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 64'd0);
    chk("R1 irq", {63'd0, irq}, 64'd0);
    chk("R1 counter", {fix_ctr[47:0], gen_ctr[47:0]}, 96'd0);
    rd_chk("R1 ctl read", 4'd0);

    // R10 control readback masks to 12 bits
    wreg(4'd0, 64'hFFFF_FFFF_FFFF_F5A3);
    rd_chk("R10 ctl read", 4'd0);
    chk("R10 ctl upper", rdata, 64'h5A3);

    // R2 supervisor-only, user-only, neither
    wreg(4'd0, 64'h021);
    priv = 2'd0; fix_evt = 6'b010101; tick();
    chk("R2 sup at level 0", {16'd0, fix_ctr[47:0]}, 64'h5A3_0000_0001 & 64'h1);
    cmp_all();
    priv = 2'd3; fix_evt = 6'b010101; tick();
    chk("R2 user at level 3", {16'd0, fix_ctr[95:48]}, 64'd1);
    chk("R2 disabled holds", {16'd0, fix_ctr[143:96]}, 64'd0);
    cmp_all();

    // R3 any-thread versus own-thread
    wreg(4'd0, 64'h037);
    fix_evt = 6'b001111; tick();
    chk("R3 any-thread adds two", {16'd0, fix_ctr[47:0]}, {16'd0, m_fix[0]});
    cmp_all();
    fix_evt = 6'b001010; tick();
    chk("R3 sibling ignored", {16'd0, fix_ctr[95:48]}, 64'd2);
    cmp_all();

    // R9 load beats a same-cycle event; then R5 wrap by two
    wr = 1'b1; addr = 4'd8; wdata = 64'h0000_FFFF_FFFF_FFFF; fix_evt = 6'b000011; tick();
    chk("R9 load wins", {16'd0, fix_ctr[47:0]}, 64'h0000_FFFF_FFFF_FFFF);
    chk("R9 no overflow on load", status, 64'd0);
    fix_evt = 6'b000011; tick();
    chk("R5 wrap to one", {16'd0, fix_ctr[47:0]}, 64'd1);
    chk("R5 fixed flag bit 32", status, 64'h1_0000_0000);
    chk("R8 irq masked", {63'd0, irq}, 64'd0);
    wreg(4'd0, 64'h03F);
    chk("R8 irq enabled", {63'd0, irq}, 64'd1);

    // R7 set wins over clear, then clear alone
    wreg(4'd8, 64'h0000_FFFF_FFFF_FFFF);
    wr = 1'b1; addr = 4'd2; wdata = 64'h1_0000_0000; fix_evt = 6'b000001; tick();
    chk("R7 set beats clear", status, 64'h1_0000_0000);
    wreg(4'd2, 64'h1_0000_0000);
    chk("R7 clear", status, 64'd0);
    chk("R7 irq drops", {63'd0, irq}, 64'd0);

    // R4 general wrap, R6 status write ignored
    wreg(4'd6, 64'h0000_FFFF_FFFF_FFFF);
    gen_evt = 4'b0100; priv = 2'd1; tick();
    chk("R4 general wrap", status, 64'h4);
    chk("R8 general irq", {63'd0, irq}, 64'd1);
    wreg(4'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R6 status write ignored", status, 64'h4);
    rd_chk("R6 status read", 4'd1);
    for (int a = 0; a < 16; a++) rd_chk("R11 read map", 4'(a));

    // random phase
    for (int i = 0; i < 4000; i++) begin
      priv = 2'($urandom);
      fix_evt = 6'($urandom);
      gen_evt = 4'($urandom);
      if ($urandom_range(7) == 0) begin
        wr = 1'b1;
        addr = 4'($urandom_range(10));
        wdata = {$urandom, $urandom};
        if (addr >= 4'd4 && $urandom_range(1) == 1) wdata[47:4] = '1;
      end
      tick();
      cmp_all();
      rd_chk("R11 random read", 4'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule